// File: doc/BRIEF.md
# NAND Cache Read Host Sequencer

This block is the host side of a multi-page read from an 8-bit NAND device. It fetches a run of consecutive pages that must all lie in one erase block, and it uses the device's cache read mode so that the array fetch of the next page overlaps the streaming of the current one. A request gives a start row address, a page count and the number of bytes to read from each page. The sequencer sends the opening page read with its address. It then sends one cache command per page: the "cache and continue" opcode for every page except the last, and the "cache and stop" opcode for the last. After each command it waits for the ready/busy line to go high, then strobes the read-enable pin once per byte and hands each byte to a valid/ready stream.

A request that would run past the end of its erase block is refused before any pin moves. The same applies to a request with a zero page count or a zero byte count. The refusal sets an error flag and completes at once. All NAND pins come straight from flip-flops. Every write-enable and read-enable strobe is low for one clock and high for at least one clock.

Top module: `nand_cache_rd_seq`

## Requirements
- R1: While reset is held and right after it ends: nand_ce_n=1, nand_we_n=1, nand_re_n=1, nand_cle=0, nand_ale=0, nand_dq_oe=0, and busy, done, err and out_valid are all 0.
- R2: An accepted request starts with command byte 0x00 and then five address bytes. The first two address bytes are 0x00 (column zero). The next three are the start row, least significant byte first. Command byte 0x30 follows. A byte counts as latched when nand_we_n goes low for one clock; nand_cle is 1 on command bytes and nand_ale is 1 on address bytes.
- R3: After 0x30, the sequencer waits for nand_rdy high. It then sends 0x31 if the page count is above one, or 0x3F if the page count is exactly one.
- R4: After each 0x31 or 0x3F, exactly page_bytes read strobes follow. Their bytes appear on out_data in strobe order, which is column 0 upward of the page just moved into the cache.
- R5: A run of N pages sends exactly N-1 commands 0x31 followed by one 0x3F. There are no further address bytes after the first five.
- R6: While out_valid is 1 and out_ready is 0, out_data and out_valid hold. No read strobe is issued while a byte is waiting in the output register.
- R7: A request is rejected when page_cnt is 0, when page_bytes is 0, or when (start_row mod PAGES_PER_BLK) + page_cnt is greater than PAGES_PER_BLK. On rejection err goes to 1, done pulses in the cycle after start, busy stays 0 and no NAND pin leaves its idle level. err returns to 0 when the next request is accepted.
- R8: done is a single-cycle pulse. It comes in the cycle after the last byte of the last page is taken (out_valid and out_ready both 1), and busy is 0 in that same cycle.
- R9: A start pulse while busy is 1 is ignored. The run in progress keeps its row, count and byte length.
- R10: nand_re_n is never low while the synchronised nand_rdy is low. Each wait lasts as long as the device keeps nand_rdy low, whatever that duration is.
- R11: A run that ends exactly on the last page of a block is accepted and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| start | input | 1 | Request strobe, sampled when idle |
| start_row | input | ROW_W | First page row address |
| page_cnt | input | CNT_W | Number of pages in the run |
| page_bytes | input | COL_W | Bytes to read from each page |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse (also on rejection) |
| err | output | 1 | Last request was rejected |
| out_valid | output | 1 | Output byte is present |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the byte |
| nand_ce_n | output | 1 | Chip enable, low during a run |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable strobe |
| nand_re_n | output | 1 | Read enable strobe |
| nand_dq_o | output | 8 | Bus value driven to the device |
| nand_dq_oe | output | 1 | Drive enable for nand_dq_o |
| nand_dq_i | input | 8 | Bus value read from the device |
| nand_rdy | input | 1 | Ready/busy line, high when ready |

## Verification
The runs differ in length: one page, three pages and four pages. A one-page run tells apart the direct jump from 0x30 to 0x3F. The longer runs show whether the count of 0x31 commands and the page each command exposes are right. Each byte carries a value that depends on both its row and its column, so a byte read from the wrong page or at the wrong column index shows up. Some runs stall the consumer every third cycle and others never stall it, which separates held output bytes from lost or repeated ones. Several cases bracket the block-boundary rule: an exact fit at the last page of a block, an overrun by one page, and a zero count. A start pulse during a busy run checks that the request is ignored. The device model holds ready/busy low for a different time after each cache command.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WB,
        ST_RDY,
        ST_RD_LO,
        ST_RD_HOLD
    } nrd_state_e;

    localparam logic [7:0] OP_READ       = 8'h00;
    localparam logic [7:0] OP_READ_GO    = 8'h30;
    localparam logic [7:0] OP_CACHE_NEXT = 8'h31;
    localparam logic [7:0] OP_CACHE_LAST = 8'h3F;

    typedef struct packed {
        logic       ce_n;
        logic       cle;
        logic       ale;
        logic       we_n;
        logic       re_n;
        logic       oe;
        logic [7:0] dq;
    } nrd_pins_t;

    localparam nrd_pins_t PINS_IDLE = '{ce_n: 1'b1, cle: 1'b0, ale: 1'b0,
                                        we_n: 1'b1, re_n: 1'b1, oe: 1'b0,
                                        dq: 8'h00};

endpackage

// File: rtl/nrd_sync.sv
module nrd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

    initial begin
        stages_min_chk: assert (STAGES >= 2);
    end
endmodule

// File: rtl/nrd_range_chk.sv
module nrd_range_chk #(
    parameter int PAGES_PER_BLK = 64,
    parameter int COL_W         = 13,
    localparam int BLK_W        = $clog2(PAGES_PER_BLK),
    localparam int CNT_W        = BLK_W + 1
) (
    input  logic [BLK_W-1:0] row_ofs,
    input  logic [CNT_W-1:0] cnt,
    input  logic [COL_W-1:0] bytes,
    output logic             ok
);
    localparam logic [CNT_W:0] BLK_LIMIT = (CNT_W+1)'(PAGES_PER_BLK);

    logic [CNT_W:0] end_sum;

    always_comb begin
        end_sum = (CNT_W+1)'(row_ofs) + (CNT_W+1)'(cnt);
        ok      = (cnt != '0) && (bytes != '0) && (end_sum <= BLK_LIMIT);
    end

    initial begin
        blk_pow2_chk: assert ((PAGES_PER_BLK >= 2) && ((1 << BLK_W) == PAGES_PER_BLK));
    end
endmodule

// File: rtl/nand_cache_rd_seq.sv
module nand_cache_rd_seq
    import nrd_pkg::*;
#(
    parameter int ROW_W         = 24,
    parameter int COL_W         = 13,
    parameter int PAGES_PER_BLK = 64,
    parameter int COL_CYC       = 2,
    parameter int WB_CYC        = 4,
    localparam int BLK_W        = $clog2(PAGES_PER_BLK),
    localparam int CNT_W        = BLK_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] start_row,
    input  logic [CNT_W-1:0] page_cnt,
    input  logic [COL_W-1:0] page_bytes,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_o,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_i,
    input  logic             nand_rdy
);
    localparam int ROW_CYC  = (ROW_W + 7) / 8;
    localparam int ROW_PAD  = 8 * ROW_CYC;
    localparam int ADDR_CYC = COL_CYC + ROW_CYC;
    localparam int AIDX_W   = $clog2(ADDR_CYC + 1);
    localparam int WB_W     = $clog2(WB_CYC + 1);

    localparam logic [AIDX_W-1:0] AIDX_LAST = AIDX_W'(ADDR_CYC - 1);
    localparam logic [AIDX_W-1:0] AIDX_ONE  = AIDX_W'(1);
    localparam logic [WB_W-1:0]   WB_LAST   = WB_W'(WB_CYC - 1);
    localparam logic [WB_W-1:0]   WB_ONE    = WB_W'(1);
    localparam logic [COL_W-1:0]  COL_ONE   = COL_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0]  CNT_TWO   = CNT_W'(2);

    typedef struct packed {
        nrd_state_e         st;
        logic               ph;
        logic [7:0]         op;
        logic [AIDX_W-1:0]  aidx;
        logic [ROW_W-1:0]   row;
        logic [CNT_W-1:0]   left;
        logic [COL_W-1:0]   bytes;
        logic [COL_W-1:0]   bidx;
        logic [WB_W-1:0]    wcnt;
        logic [7:0]         data;
        logic               valid;
        logic               done;
        logic               err;
        nrd_pins_t          pins;
    } seq_t;

    seq_t q, n;

    logic rdy_s;
    logic range_ok;

    nrd_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nand_rdy),
        .q     (rdy_s)
    );

    nrd_range_chk #(.PAGES_PER_BLK(PAGES_PER_BLK), .COL_W(COL_W)) u_range (
        .row_ofs (start_row[BLK_W-1:0]),
        .cnt     (page_cnt),
        .bytes   (page_bytes),
        .ok      (range_ok)
    );

    // Pin levels for a given (next) state; registered so every pin is glitch free.
    function automatic nrd_pins_t pin_decode(input nrd_state_e st, input logic ph,
                                             input logic [7:0] op, input logic [7:0] abyte);
        nrd_pins_t p;
        p = PINS_IDLE;
        if (st != ST_IDLE) p.ce_n = 1'b0;
        case (st)
            ST_CMD: begin
                p.cle  = 1'b1;
                p.we_n = ph;
                p.oe   = 1'b1;
                p.dq   = op;
            end
            ST_ADDR: begin
                p.ale  = 1'b1;
                p.we_n = ph;
                p.oe   = 1'b1;
                p.dq   = abyte;
            end
            ST_RD_LO: p.re_n = 1'b0;
            default: ;
        endcase
        return p;
    endfunction

    logic [ROW_PAD-1:0]    row_pad;
    logic [8*ADDR_CYC-1:0] addr_vec;
    logic [7:0]            addr_byte;

    always_comb begin
        n      = q;
        n.done = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (range_ok) begin
                        n.err   = 1'b0;
                        n.row   = start_row;
                        n.left  = page_cnt;
                        n.bytes = page_bytes;
                        n.op    = OP_READ;
                        n.ph    = 1'b0;
                        n.st    = ST_CMD;
                    end else begin
                        n.err  = 1'b1;
                        n.done = 1'b1;
                    end
                end
            end
            ST_CMD: begin
                if (!q.ph) begin
                    n.ph = 1'b1;
                end else begin
                    n.ph = 1'b0;
                    if (q.op == OP_READ) begin
                        n.st   = ST_ADDR;
                        n.aidx = '0;
                    end else begin
                        n.st   = ST_WB;
                        n.wcnt = '0;
                    end
                end
            end
            ST_ADDR: begin
                if (!q.ph) begin
                    n.ph = 1'b1;
                end else begin
                    n.ph = 1'b0;
                    if (q.aidx == AIDX_LAST) begin
                        n.st = ST_CMD;
                        n.op = OP_READ_GO;
                    end else begin
                        n.aidx = q.aidx + AIDX_ONE;
                    end
                end
            end
            ST_WB: begin
                if (q.wcnt == WB_LAST) n.st = ST_RDY;
                else                   n.wcnt = q.wcnt + WB_ONE;
            end
            ST_RDY: begin
                if (rdy_s) begin
                    if (q.op == OP_READ_GO) begin
                        n.st = ST_CMD;
                        n.ph = 1'b0;
                        n.op = (q.left > CNT_ONE) ? OP_CACHE_NEXT : OP_CACHE_LAST;
                    end else begin
                        n.st   = ST_RD_LO;
                        n.bidx = '0;
                    end
                end
            end
            ST_RD_LO: begin
                n.data  = nand_dq_i;
                n.valid = 1'b1;
                n.st    = ST_RD_HOLD;
            end
            ST_RD_HOLD: begin
                if (out_ready) begin
                    n.valid = 1'b0;
                    if ((q.bidx + COL_ONE) == q.bytes) begin
                        n.left = q.left - CNT_ONE;
                        if (q.left == CNT_ONE) begin
                            n.st   = ST_IDLE;
                            n.done = 1'b1;
                        end else begin
                            n.st = ST_CMD;
                            n.ph = 1'b0;
                            n.op = (q.left > CNT_TWO) ? OP_CACHE_NEXT : OP_CACHE_LAST;
                        end
                    end else begin
                        n.bidx = q.bidx + COL_ONE;
                        n.st   = ST_RD_LO;
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase

        row_pad   = ROW_PAD'(n.row);
        addr_vec  = {row_pad, {(8*COL_CYC){1'b0}}};
        addr_byte = addr_vec[8*int'(n.aidx) +: 8];
        n.pins    = pin_decode(n.st, n.ph, n.op, addr_byte);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.pins  <= PINS_IDLE;
        end else begin
            q <= n;
        end
    end

    assign busy       = (q.st != ST_IDLE);
    assign done       = q.done;
    assign err        = q.err;
    assign out_valid  = q.valid;
    assign out_data   = q.data;
    assign nand_ce_n  = q.pins.ce_n;
    assign nand_cle   = q.pins.cle;
    assign nand_ale   = q.pins.ale;
    assign nand_we_n  = q.pins.we_n;
    assign nand_re_n  = q.pins.re_n;
    assign nand_dq_o  = q.pins.dq;
    assign nand_dq_oe = q.pins.oe;

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R10
    re_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> rdy_s);

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6
    re_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !out_valid);

    // R7
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !range_ok) |=> (!busy && err && done && nand_ce_n));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(q.row));

    initial begin
        wb_guard_chk: assert (WB_CYC >= 3);
    end
endmodule

// File: tb/sim_nand_cache_rd_seq.sv
`timescale 1ns/1ps
module sim_nand_cache_rd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] st_row = '0;
    logic [6:0]  st_cnt = '0;
    logic [12:0] st_bytes = '0;
    logic        busy, done, err, out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o, nand_dq_i;
    logic        nand_rdy = 1'b1;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    nand_cache_rd_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_row(st_row),
        .page_cnt(st_cnt), .page_bytes(st_bytes), .busy(busy), .done(done),
        .err(err), .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rdy(nand_rdy)
    );

    function automatic logic [7:0] pat(input logic [23:0] r, input int c);
        logic [7:0] m;
        m = r[7:0] * 8'd7;
        return m ^ r[15:8] ^ 8'(c * 3 + 1);
    endfunction

    // ---------------- device model and consumer ----------------
    int          clr_req = 0;
    int          clr_seen = 0;
    logic        stall = 1'b0;
    int          busy_cnt = 0;
    logic [23:0] data_row = '0, cache_row = '0, addr_row = '0;
    int          addr_n = 0;
    int          col = 0;
    logic        prev_re = 1'b1;
    logic [8:0]  log_q [0:63];
    int          log_n = 0;
    int          re_cnt = 0;
    int          viol_re_busy = 0, viol_re_valid = 0, viol_hold = 0;
    int          cyc = 0;
    logic [7:0]  rx [0:255];
    int          rx_n = 0;
    logic        prev_wait = 1'b0;
    logic [7:0]  prev_data = '0;

    assign nand_dq_i = pat(cache_row, col);

    always @(negedge clk) begin
        cyc++;
        if (clr_req != clr_seen) begin
            clr_seen = clr_req;
            log_n = 0; re_cnt = 0; rx_n = 0;
            viol_re_busy = 0; viol_re_valid = 0; viol_hold = 0;
        end
        if (busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) nand_rdy = 1'b1;
        end
        if (!nand_ce_n && !nand_we_n) begin
            if (log_n < 64) log_q[log_n] = {nand_cle, nand_dq_o};
            log_n++;
            if (nand_cle) begin
                case (nand_dq_o)
                    8'h00: begin addr_n = 0; addr_row = '0; end
                    8'h30: begin data_row = addr_row; nand_rdy = 1'b0; busy_cnt = 30; end
                    8'h31: begin
                        cache_row = data_row; data_row = data_row + 24'd1; col = 0;
                        nand_rdy = 1'b0; busy_cnt = 5 + 7 * (log_n % 3);
                    end
                    8'h3F: begin cache_row = data_row; col = 0; nand_rdy = 1'b0; busy_cnt = 4; end
                    default: ;
                endcase
            end else if (nand_ale) begin
                if (addr_n >= 2 && addr_n < 5) addr_row[8*(addr_n-2) +: 8] = nand_dq_o;
                addr_n++;
            end
        end
        if (!nand_re_n) begin
            re_cnt++;
            if (!nand_rdy) viol_re_busy++;
            if (out_valid) viol_re_valid++;
        end
        if (nand_re_n && !prev_re) col++;
        prev_re = nand_re_n;
        if (prev_wait && !(out_valid && out_data == prev_data)) viol_hold++;
        out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
        prev_wait = out_valid && !out_ready;
        prev_data = out_data;
        if (out_valid && out_ready) begin
            rx[rx_n[7:0]] = out_data;
            rx_n++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        clr_req++;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start(input logic [23:0] row, input logic [6:0] cnt,
                               input logic [12:0] nb);
        st_row = row; st_cnt = cnt; st_bytes = nb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        // R1
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
            "R1", "pins idle in reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 6'b111000);
        chk(!busy && !done && !err && !out_valid, "R1", "status in reset",
            {busy, done, err, out_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe && !busy && !out_valid,
            "R1", "idle after reset", {nand_ce_n, nand_we_n, nand_re_n, nand_dq_oe, busy, out_valid}, 6'b111000);
    endtask

    task automatic t_run(input string tag, input logic [23:0] row, input int cnt,
                         input int nb, input bit stl, input bit poke);
        int  waited;
        bit  seen;
        int  bad;
        int  first_i;
        logic [8:0] exp_log [0:63];
        int  exp_n;
        clear_model();
        stall = stl;
        pulse_start(row, 7'(cnt), 13'(nb));
        if (poke) begin
            repeat (10) @(negedge clk);
            // R9: a second request while busy must not disturb the run
            chk(busy == 1'b1, "R9", {tag, " busy at poke"}, busy, 1);
            pulse_start(row + 24'd9, 7'd1, 13'd2);
        end
        waited = 0;
        seen = 1'b0;
        while (!seen && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (done) seen = 1'b1;
        end
        // R8
        chk(seen, "R8", {tag, " done pulse"}, seen, 1);
        chk(!busy, "R8", {tag, " busy low with done"}, busy, 0);
        @(negedge clk);
        chk(!done, "R8", {tag, " done single cycle"}, done, 0);
        stall = 1'b0;
        chk(!err, "R7", {tag, " err clear on accepted run"}, err, 0);

        exp_log[0] = 9'h100;
        exp_log[1] = 9'h000;
        exp_log[2] = 9'h000;
        exp_log[3] = {1'b0, row[7:0]};
        exp_log[4] = {1'b0, row[15:8]};
        exp_log[5] = {1'b0, row[23:16]};
        exp_log[6] = 9'h130;
        for (int i = 0; i < cnt - 1; i++) exp_log[7+i] = 9'h131;
        exp_log[6+cnt] = 9'h13F;
        exp_n = 7 + cnt;

        chk(log_n == exp_n, "R5", {tag, " latched byte count"}, log_n, exp_n);
        bad = 0; first_i = 0;
        for (int i = 0; i < 7; i++)
            if (log_q[i] !== exp_log[i]) begin if (bad == 0) first_i = i; bad++; end
        // R2
        chk(bad == 0, "R2", {tag, " opening read sequence"}, log_q[first_i], exp_log[first_i]);
        bad = 0; first_i = 7;
        for (int i = 7; i < exp_n && i < 64; i++)
            if (log_q[i] !== exp_log[i]) begin if (bad == 0) first_i = i; bad++; end
        // R3 / R5
        chk(bad == 0, "R5", {tag, " cache command order"}, log_q[first_i], exp_log[first_i]);
        if (cnt == 1)
            chk(log_q[7] == 9'h13F, "R3", {tag, " single page goes straight to last"}, log_q[7], 9'h13F);

        // R4
        chk(re_cnt == cnt * nb, "R4", {tag, " read strobe count"}, re_cnt, cnt * nb);
        chk(rx_n == cnt * nb, "R4", {tag, " bytes delivered"}, rx_n, cnt * nb);
        bad = 0;
        for (int p = 0; p < cnt; p++)
            for (int c = 0; c < nb; c++)
                if (bad == 0 && rx[p*nb + c] !== pat(row + 24'(p), c)) begin
                    bad++;
                    chk(1'b0, "R4", {tag, " byte value"}, rx[p*nb + c], pat(row + 24'(p), c));
                end
        if (bad == 0) chk(1'b1, "R4", {tag, " byte value"}, 0, 0);
        // R10
        chk(viol_re_busy == 0, "R10", {tag, " no read strobe while busy"}, viol_re_busy, 0);
        // R6
        chk(viol_re_valid == 0 && viol_hold == 0, "R6", {tag, " output held under stall"},
            viol_re_valid + viol_hold, 0);
    endtask

    task automatic t_reject(input string tag, input logic [23:0] row, input int cnt, input int nb);
        clear_model();
        pulse_start(row, 7'(cnt), 13'(nb));
        // R7: done and err visible the cycle after start
        chk(done && err && !busy, "R7", {tag, " reject flags"}, {done, err, busy}, 3'b110);
        repeat (12) @(negedge clk);
        chk(log_n == 0 && re_cnt == 0 && nand_ce_n, "R7", {tag, " no pin activity"},
            log_n + re_cnt, 0);
        chk(err && !busy, "R7", {tag, " err held"}, {err, busy}, 2'b10);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_run("single", 24'h000005, 1, 8, 1'b0, 1'b0);
        t_run("three_stall", 24'h012340, 3, 5, 1'b1, 1'b1);
        t_reject("overrun", 24'h00007C, 5, 3);
        t_reject("zero_cnt", 24'h000010, 0, 3);
        // R11: offset 60 plus four pages ends exactly at the block edge
        t_run("edge_fit", 24'h00007C, 4, 3, 1'b0, 1'b0);
        t_run("two_long", 24'hABCD41, 2, 16, 1'b1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule